// File: doc/BRIEF.md
# Nibble-Stack Call/Return Frame Sequencer

This block is the stack-control engine of a small 4-bit processor core. It owns the stack pointer and runs the stack side of subroutine calls, returns, interrupt returns and save/restore of a register pair or of the two bank-select nibbles. It does this through a nibble-wide data memory port. The memory is read combinationally: read data belongs to the address driven in the same cycle. Writes take effect at the clock edge. The sequencer makes exactly one memory access per clock.

A frame-format input picks between a compact frame of four nibbles and an extended frame of six nibbles. Each format spreads the 11-bit return address and the two memory/register bank enable flags over the nibbles of the frame in its own fixed pattern. The surrounding core supplies an operation code, its operands and a one-cycle start strobe. When the operation ends, it picks up the restored program counter, flags, status byte, register pair or bank-select values, together with a skip request for the following instruction, all in the cycle marked by the done strobe.

Top module: `sfs_frame_seq`

## Requirements
- R1: While reset is asserted and right after it, the stack pointer equals the reset value (0 by default), and busy, done and memory write enable are all low.
- R2: The operation codes are call=1, return=2, return-and-skip=3, interrupt return=4, pair push=5, pair pop=6, bank push=7 and bank pop=8. A start with any other code, or a start while busy, is ignored and leaves the stack pointer and memory unchanged.
- R3: Once started, the block makes one access per cycle. The access counts are: compact call 4, extended call 5, either return 4, interrupt return 5, and every push or pop 2. Done is high only in the cycle of the last access, the stack pointer port already shows the new value in that cycle, and busy drops after it.
- R4: A compact call with return address P writes P[7:4] to SP-1, P[3:0] to SP-2, {MBE,RBE,0,0} to SP-3 and {0,P[10:8]} to SP-4, then sets SP to SP-4.
- R5: An extended call writes {0,0,MBE,RBE} to SP-2, P[7:4] to SP-3, P[3:0] to SP-4, 0000 to SP-5 and {0,P[10:8]} to SP-6. It leaves SP-1 untouched and sets SP to SP-6.
- R6: A compact return restores PC = {(SP)[2:0], (SP+3), (SP+2)}, takes MBE from bit 3 and RBE from bit 2 of (SP+1) and ignores that nibble's low bits, then adds 4 to SP.
- R7: An extended return restores the PC from the same nibbles and takes MBE from bit 1 and RBE from bit 0 of (SP+4). It ignores (SP+1) and the upper bits of (SP+4), then adds 6 to SP.
- R8: Return-and-skip restores exactly what a plain return restores in the selected format and raises the skip request in its done cycle. No other operation raises it.
- R9: An interrupt return restores the PC as in R6 and the 8-bit status as {(SP+4),(SP+5)}, then adds 6 to SP. This is the same in both formats.
- R10: A pair push writes pair[7:4] to SP-1 and pair[3:0] to SP-2 and subtracts 2 from SP. A pair pop returns {(SP+1),(SP)} and adds 2.
- R11: A bank push writes the memory bank select to SP-1 and the register bank select to SP-2 and subtracts 2. A bank pop returns them from SP+1 and SP and adds 2.
- R12: All stack pointer and frame address arithmetic wraps modulo 256.
- R13: In a call's done cycle the program-counter load strobe is high and the PC output equals the call target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| op_code | input | 4 | Operation code (see R2) |
| long_mode | input | 1 | 1 selects the six-nibble frame |
| call_target | input | 11 | Destination of a call |
| pc_in | input | 11 | Return address saved by a call |
| mbe_in | input | 1 | Memory bank enable flag to save |
| rbe_in | input | 1 | Register bank enable flag to save |
| pair_in | input | 8 | Register pair to push |
| mbs_in | input | 4 | Memory bank select to push |
| rbs_in | input | 4 | Register bank select to push |
| mem_addr | output | 8 | Data memory nibble address |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 4 | Data memory read nibble for mem_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last access of the operation |
| sp | output | 8 | Stack pointer |
| pc_next | output | 11 | Restored or target program counter |
| pc_load | output | 1 | pc_next valid (done cycle) |
| mbe_out | output | 1 | Restored memory bank enable |
| rbe_out | output | 1 | Restored register bank enable |
| flags_load | output | 1 | Restored flags valid |
| psw_out | output | 8 | Restored status byte |
| psw_load | output | 1 | psw_out valid |
| pair_out | output | 8 | Popped register pair |
| pair_load | output | 1 | pair_out valid |
| mbs_out | output | 4 | Popped memory bank select |
| rbs_out | output | 4 | Popped register bank select |
| bank_load | output | 1 | Bank select outputs valid |
| skip_req | output | 1 | Skip the next instruction |

## Verification
Thirty-two call/return round trips, sixteen in each frame format, each use a different return address, target and flag pair. Each one is framed by a pair push, and these pushes drive the stack pointer down across zero, so frame placement, nibble order and address wrap are all exercised. Before each return, the bench sets the don't-care bits and the skipped nibble to ones. A design that read the wrong nibble or the wrong flag bits would then restore visibly wrong values. Alternating plain returns with return-and-skip separates the skip request from the restore path. Interrupt returns, run on bench-written frames with eight distinct byte patterns, separate the status byte halves from the address nibbles. A start strobe issued mid-operation and several illegal codes show that the idle-only acceptance rule holds.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int NIB_W   = 4;
    localparam int PC_W    = 11;
    localparam int PC_HI_W = PC_W - 2 * NIB_W;
    localparam int BYTE_W  = 2 * NIB_W;
    localparam int STEP_W  = 3;
    localparam int OFF_W   = 4;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 4'd0,
        OP_CALL      = 4'd1,
        OP_RET       = 4'd2,
        OP_RETS      = 4'd3,
        OP_RETI      = 4'd4,
        OP_PUSH_PAIR = 4'd5,
        OP_POP_PAIR  = 4'd6,
        OP_PUSH_BANK = 4'd7,
        OP_POP_BANK  = 4'd8
    } op_e;

    // Meaning of one frame nibble
    typedef enum logic [3:0] {
        FLD_ZERO,
        FLD_PC_HI,
        FLD_PC_MID,
        FLD_PC_LO,
        FLD_FLAG_UP,
        FLD_FLAG_DN,
        FLD_PSW_HI,
        FLD_PSW_LO,
        FLD_PAIR_HI,
        FLD_PAIR_LO,
        FLD_MBS,
        FLD_RBS
    } field_e;

    typedef struct packed {
        logic signed [OFF_W-1:0] off;
        logic                    write;
        field_e                  field;
        logic                    last;
    } access_t;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              mbe;
        logic              rbe;
        logic [BYTE_W-1:0] psw;
        logic [BYTE_W-1:0] pair;
        logic [NIB_W-1:0]  mbs;
        logic [NIB_W-1:0]  rbs;
    } cap_t;

    function automatic logic op_is_valid(input logic [OP_W-1:0] code);
        return (code >= 4'd1) && (code <= 4'd8);
    endfunction

endpackage

// File: rtl/sfs_frame_plan.sv
// Per-step access table: which offset, direction and frame field each step uses.
module sfs_frame_plan
    import sfs_pkg::*;
(
    input  op_e                     op,
    input  logic                    long_mode,
    input  logic [STEP_W-1:0]       step,
    output access_t                 acc,
    output logic signed [OFF_W-1:0] sp_delta
);

    function automatic access_t mk(input int o, input logic w, input field_e f, input logic l);
        access_t a;
        a.off   = OFF_W'(o);
        a.write = w;
        a.field = f;
        a.last  = l;
        return a;
    endfunction

    always_comb begin
        acc      = mk(0, 1'b0, FLD_ZERO, 1'b1);
        sp_delta = '0;
        case (op)
            OP_CALL: begin
                if (!long_mode) begin
                    sp_delta = -4'sd4;
                    case (step)
                        3'd0:    acc = mk(-1, 1'b1, FLD_PC_MID,  1'b0);
                        3'd1:    acc = mk(-2, 1'b1, FLD_PC_LO,   1'b0);
                        3'd2:    acc = mk(-3, 1'b1, FLD_FLAG_UP, 1'b0);
                        default: acc = mk(-4, 1'b1, FLD_PC_HI,   1'b1);
                    endcase
                end else begin
                    sp_delta = -4'sd6;
                    case (step)
                        3'd0:    acc = mk(-2, 1'b1, FLD_FLAG_DN, 1'b0);
                        3'd1:    acc = mk(-3, 1'b1, FLD_PC_MID,  1'b0);
                        3'd2:    acc = mk(-4, 1'b1, FLD_PC_LO,   1'b0);
                        3'd3:    acc = mk(-5, 1'b1, FLD_ZERO,    1'b0);
                        default: acc = mk(-6, 1'b1, FLD_PC_HI,   1'b1);
                    endcase
                end
            end
            OP_RET, OP_RETS: begin
                if (!long_mode) begin
                    sp_delta = 4'sd4;
                    case (step)
                        3'd0:    acc = mk(0, 1'b0, FLD_PC_HI,   1'b0);
                        3'd1:    acc = mk(1, 1'b0, FLD_FLAG_UP, 1'b0);
                        3'd2:    acc = mk(2, 1'b0, FLD_PC_LO,   1'b0);
                        default: acc = mk(3, 1'b0, FLD_PC_MID,  1'b1);
                    endcase
                end else begin
                    sp_delta = 4'sd6;
                    case (step)
                        3'd0:    acc = mk(0, 1'b0, FLD_PC_HI,   1'b0);
                        3'd1:    acc = mk(2, 1'b0, FLD_PC_LO,   1'b0);
                        3'd2:    acc = mk(3, 1'b0, FLD_PC_MID,  1'b0);
                        default: acc = mk(4, 1'b0, FLD_FLAG_DN, 1'b1);
                    endcase
                end
            end
            OP_RETI: begin
                sp_delta = 4'sd6;
                case (step)
                    3'd0:    acc = mk(0, 1'b0, FLD_PC_HI,  1'b0);
                    3'd1:    acc = mk(2, 1'b0, FLD_PC_LO,  1'b0);
                    3'd2:    acc = mk(3, 1'b0, FLD_PC_MID, 1'b0);
                    3'd3:    acc = mk(4, 1'b0, FLD_PSW_HI, 1'b0);
                    default: acc = mk(5, 1'b0, FLD_PSW_LO, 1'b1);
                endcase
            end
            OP_PUSH_PAIR: begin
                sp_delta = -4'sd2;
                if (step == 3'd0) acc = mk(-1, 1'b1, FLD_PAIR_HI, 1'b0);
                else              acc = mk(-2, 1'b1, FLD_PAIR_LO, 1'b1);
            end
            OP_POP_PAIR: begin
                sp_delta = 4'sd2;
                if (step == 3'd0) acc = mk(1, 1'b0, FLD_PAIR_HI, 1'b0);
                else              acc = mk(0, 1'b0, FLD_PAIR_LO, 1'b1);
            end
            OP_PUSH_BANK: begin
                sp_delta = -4'sd2;
                if (step == 3'd0) acc = mk(-1, 1'b1, FLD_MBS, 1'b0);
                else              acc = mk(-2, 1'b1, FLD_RBS, 1'b1);
            end
            OP_POP_BANK: begin
                sp_delta = 4'sd2;
                if (step == 3'd0) acc = mk(1, 1'b0, FLD_MBS, 1'b0);
                else              acc = mk(0, 1'b0, FLD_RBS, 1'b1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sfs_nibble_pack.sv
// Builds the nibble written for a frame field; unused bits are zero.
module sfs_nibble_pack
    import sfs_pkg::*;
(
    input  field_e             field,
    input  logic [PC_W-1:0]    pc,
    input  logic               mbe,
    input  logic               rbe,
    input  logic [BYTE_W-1:0]  pair,
    input  logic [NIB_W-1:0]   mbs,
    input  logic [NIB_W-1:0]   rbs,
    output logic [NIB_W-1:0]   wdata
);

    always_comb begin
        wdata = '0;
        case (field)
            FLD_PC_HI:   wdata = NIB_W'(pc[PC_W-1:2*NIB_W]);
            FLD_PC_MID:  wdata = pc[2*NIB_W-1:NIB_W];
            FLD_PC_LO:   wdata = pc[NIB_W-1:0];
            FLD_FLAG_UP: wdata = {mbe, rbe, 2'b00};
            FLD_FLAG_DN: wdata = {2'b00, mbe, rbe};
            FLD_PAIR_HI: wdata = pair[BYTE_W-1:NIB_W];
            FLD_PAIR_LO: wdata = pair[NIB_W-1:0];
            FLD_MBS:     wdata = mbs;
            FLD_RBS:     wdata = rbs;
            default:     wdata = '0;
        endcase
    end

endmodule

// File: rtl/sfs_nibble_unpack.sv
// Merges a read nibble into the restored-state record.
module sfs_nibble_unpack
    import sfs_pkg::*;
(
    input  logic             en,
    input  field_e           field,
    input  logic [NIB_W-1:0] rdata,
    input  cap_t             cap_in,
    output cap_t             cap_out
);

    always_comb begin
        cap_out = cap_in;
        if (en) begin
            case (field)
                FLD_PC_HI:   cap_out.pc[PC_W-1:2*NIB_W]     = rdata[PC_HI_W-1:0];
                FLD_PC_MID:  cap_out.pc[2*NIB_W-1:NIB_W]    = rdata;
                FLD_PC_LO:   cap_out.pc[NIB_W-1:0]          = rdata;
                FLD_FLAG_UP: begin
                    cap_out.mbe = rdata[3];
                    cap_out.rbe = rdata[2];
                end
                FLD_FLAG_DN: begin
                    cap_out.mbe = rdata[1];
                    cap_out.rbe = rdata[0];
                end
                FLD_PSW_HI:  cap_out.psw[BYTE_W-1:NIB_W]    = rdata;
                FLD_PSW_LO:  cap_out.psw[NIB_W-1:0]         = rdata;
                FLD_PAIR_HI: cap_out.pair[BYTE_W-1:NIB_W]   = rdata;
                FLD_PAIR_LO: cap_out.pair[NIB_W-1:0]        = rdata;
                FLD_MBS:     cap_out.mbs                    = rdata;
                FLD_RBS:     cap_out.rbs                    = rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sfs_frame_seq.sv
module sfs_frame_seq
    import sfs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned SP_RESET = 0
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OP_W-1:0]    op_code,
    input  logic               long_mode,
    input  logic [PC_W-1:0]    call_target,
    input  logic [PC_W-1:0]    pc_in,
    input  logic               mbe_in,
    input  logic               rbe_in,
    input  logic [BYTE_W-1:0]  pair_in,
    input  logic [NIB_W-1:0]   mbs_in,
    input  logic [NIB_W-1:0]   rbs_in,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NIB_W-1:0]   mem_wdata,
    output logic               mem_we,
    input  logic [NIB_W-1:0]   mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  sp,
    output logic [PC_W-1:0]    pc_next,
    output logic               pc_load,
    output logic               mbe_out,
    output logic               rbe_out,
    output logic               flags_load,
    output logic [BYTE_W-1:0]  psw_out,
    output logic               psw_load,
    output logic [BYTE_W-1:0]  pair_out,
    output logic               pair_load,
    output logic [NIB_W-1:0]   mbs_out,
    output logic [NIB_W-1:0]   rbs_out,
    output logic               bank_load,
    output logic               skip_req
);

    localparam int EXT_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic               busy;
        op_e                op;
        logic               long_mode;
        logic [STEP_W-1:0]  step;
        logic [ADDR_W-1:0]  sp;
        logic [PC_W-1:0]    ret_pc;
        logic [PC_W-1:0]    target;
        logic               mbe;
        logic               rbe;
        logic [BYTE_W-1:0]  pair;
        logic [NIB_W-1:0]   mbs;
        logic [NIB_W-1:0]   rbs;
        cap_t               cap;
    } state_t;

    state_t st_d, st_q;

    access_t                 acc;
    logic signed [OFF_W-1:0] sp_delta;
    cap_t                    cap_nx;
    logic [ADDR_W-1:0]       sp_after;
    logic                    is_call, is_ret, is_rets, is_reti;

    sfs_frame_plan u_plan (
        .op        (st_q.op),
        .long_mode (st_q.long_mode),
        .step      (st_q.step),
        .acc       (acc),
        .sp_delta  (sp_delta)
    );

    sfs_nibble_pack u_pack (
        .field (acc.field),
        .pc    (st_q.ret_pc),
        .mbe   (st_q.mbe),
        .rbe   (st_q.rbe),
        .pair  (st_q.pair),
        .mbs   (st_q.mbs),
        .rbs   (st_q.rbs),
        .wdata (mem_wdata)
    );

    sfs_nibble_unpack u_unpack (
        .en      (st_q.busy && !acc.write),
        .field   (acc.field),
        .rdata   (mem_rdata),
        .cap_in  (st_q.cap),
        .cap_out (cap_nx)
    );

    assign mem_addr = st_q.sp + {{EXT_W{acc.off[OFF_W-1]}}, acc.off};
    assign sp_after = st_q.sp + {{EXT_W{sp_delta[OFF_W-1]}}, sp_delta};

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start && op_is_valid(op_code)) begin
                st_d.busy      = 1'b1;
                st_d.op        = op_e'(op_code);
                st_d.long_mode = long_mode;
                st_d.step      = '0;
                st_d.ret_pc    = pc_in;
                st_d.target    = call_target;
                st_d.mbe       = mbe_in;
                st_d.rbe       = rbe_in;
                st_d.pair      = pair_in;
                st_d.mbs       = mbs_in;
                st_d.rbs       = rbs_in;
                st_d.cap       = '0;
            end
        end else begin
            st_d.cap = cap_nx;
            if (acc.last) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
                st_d.sp   = sp_after;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sp <= ADDR_W'(SP_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign is_call = (st_q.op == OP_CALL);
    assign is_ret  = (st_q.op == OP_RET);
    assign is_rets = (st_q.op == OP_RETS);
    assign is_reti = (st_q.op == OP_RETI);

    assign busy       = st_q.busy;
    assign done       = st_q.busy && acc.last;
    assign mem_we     = st_q.busy && acc.write;
    assign sp         = done ? sp_after : st_q.sp;
    assign pc_next    = is_call ? st_q.target : cap_nx.pc;
    assign pc_load    = done && (is_call || is_ret || is_rets || is_reti);
    assign mbe_out    = cap_nx.mbe;
    assign rbe_out    = cap_nx.rbe;
    assign flags_load = done && (is_ret || is_rets);
    assign psw_out    = cap_nx.psw;
    assign psw_load   = done && is_reti;
    assign pair_out   = cap_nx.pair;
    assign pair_load  = done && (st_q.op == OP_POP_PAIR);
    assign mbs_out    = cap_nx.mbs;
    assign rbs_out    = cap_nx.rbs;
    assign bank_load  = done && (st_q.op == OP_POP_BANK);
    assign skip_req   = done && is_rets;

endmodule

// File: rtl/sfs_frame_seq_chk.sv
module sfs_frame_seq_chk #(
    parameter int ADDR_W = 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] sp,
    input logic              skip_req,
    input logic              flags_load,
    input logic              psw_load,
    input logic              pair_load,
    input logic              bank_load
);

    a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r3_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r3_sp_kept_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sp == $past(sp)));

    a_r2_idle_sp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sp));

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> done);

    a_r9_single_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_load, psw_load, pair_load, bank_load}));

endmodule

bind sfs_frame_seq sfs_frame_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .sp         (sp),
    .skip_req   (skip_req),
    .flags_load (flags_load),
    .psw_load   (psw_load),
    .pair_load  (pair_load),
    .bank_load  (bank_load)
);

// File: tb/tb_sfs_frame_seq.sv
module tb_sfs_frame_seq;

    localparam int CLK_P = 10;
    localparam logic [3:0] C_CALL = 4'd1, C_RET = 4'd2, C_RETS = 4'd3, C_RETI = 4'd4;
    localparam logic [3:0] C_PUSHP = 4'd5, C_POPP = 4'd6, C_PUSHB = 4'd7, C_POPB = 4'd8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0]  op_code = '0;
    logic        long_mode = 1'b0;
    logic [10:0] call_target = '0, pc_in = '0;
    logic        mbe_in = 1'b0, rbe_in = 1'b0;
    logic [7:0]  pair_in = '0;
    logic [3:0]  mbs_in = '0, rbs_in = '0;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_wdata, mem_rdata;
    logic        mem_we, busy, done, pc_load, mbe_out, rbe_out, flags_load;
    logic        psw_load, pair_load, bank_load, skip_req;
    logic [7:0]  sp, psw_out, pair_out;
    logic [10:0] pc_next;
    logic [3:0]  mbs_out, rbs_out;

    logic [3:0] mem [256];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    always #(CLK_P/2) clk = ~clk;

    sfs_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .long_mode(long_mode),
        .call_target(call_target), .pc_in(pc_in), .mbe_in(mbe_in), .rbe_in(rbe_in),
        .pair_in(pair_in), .mbs_in(mbs_in), .rbs_in(rbs_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .sp(sp), .pc_next(pc_next), .pc_load(pc_load), .mbe_out(mbe_out),
        .rbe_out(rbe_out), .flags_load(flags_load), .psw_out(psw_out), .psw_load(psw_load),
        .pair_out(pair_out), .pair_load(pair_load), .mbs_out(mbs_out), .rbs_out(rbs_out),
        .bank_load(bank_load), .skip_req(skip_req)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] a8(input logic [7:0] b, input int d);
        return 8'(int'(b) + d);
    endfunction

    int r_cycles, r_dones;
    logic [10:0] r_pc;
    logic r_pcl, r_mbe, r_rbe, r_fl, r_psl, r_pl, r_bl, r_skip;
    logic [7:0] r_psw, r_pair, r_sp;
    logic [3:0] r_mbs, r_rbs;

    task automatic run_op(input logic [3:0] code, input bit poke);
        int guard;
        op_code = code;
        start   = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        r_cycles = 0;
        r_dones  = 0;
        guard    = 0;
        while (busy && guard < 20) begin
            if (poke && r_cycles == 0) begin
                start   = 1'b1;
                op_code = C_POPB;
            end else begin
                start = 1'b0;
            end
            r_cycles++;
            if (done) begin
                r_dones++;
                r_pc = pc_next;  r_pcl = pc_load;  r_mbe = mbe_out; r_rbe = rbe_out;
                r_fl = flags_load; r_psw = psw_out; r_psl = psw_load; r_pair = pair_out;
                r_pl = pair_load; r_mbs = mbs_out; r_rbs = rbs_out; r_bl = bank_load;
                r_skip = skip_req; r_sp = sp;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
    endtask

    logic [7:0] pair_hist [32];

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int depth;
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sp", int'(sp), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sp after release", int'(sp), 0);

        // R2 invalid codes ignored
        for (int c = 0; c < 4; c++) begin
            logic [3:0] code;
            code = (c == 0) ? 4'd0 : (c == 1) ? 4'd9 : (c == 2) ? 4'd12 : 4'd15;
            run_op(code, 1'b0);
            chk("R2", "invalid code cycles", r_cycles, 0);
            chk("R2", "invalid code sp", int'(sp), 0);
        end

        depth = 0;
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 16; k++) begin
                logic [10:0] pc, tg;
                logic fm, fr;
                logic [7:0] s0, s1, pv;
                long_mode = m[0];
                pv = 8'(k * 37 + m * 91 + 5);
                s0 = sp;
                pair_in = pv;
                run_op(C_PUSHP, k == 3);
                chk("R3", "pair push cycles", r_cycles, 2);
                chk("R12", "pair push sp wrap", int'(r_sp), int'(a8(s0, -2)));
                chk("R10", "pair push hi", int'(mem[a8(s0, -1)]), int'(pv[7:4]));
                chk("R10", "pair push lo", int'(mem[a8(s0, -2)]), int'(pv[3:0]));
                if (k == 3) begin
                    chk("R2", "start while busy ignored busy", int'(busy), 0);
                    chk("R2", "start while busy ignored sp", int'(sp), int'(a8(s0, -2)));
                end
                pair_hist[depth] = pv;
                depth++;

                pc = 11'(k * 293 + m * 77 + 1);
                tg = 11'(k * 111 + 3);
                fm = k[0];
                fr = k[1];
                s0 = sp;
                mem[a8(s0, -1)] = 4'hA;
                pc_in = pc; call_target = tg; mbe_in = fm; rbe_in = fr;
                run_op(C_CALL, 1'b0);
                chk("R13", "call pc", int'(r_pc), int'(tg));
                chk("R13", "call pc_load", int'(r_pcl), 1);
                chk("R3", "call done count", r_dones, 1);
                if (m == 0) begin
                    chk("R3", "short call cycles", r_cycles, 4);
                    chk("R4", "short call sp", int'(r_sp), int'(a8(s0, -4)));
                    chk("R4", "nib -1", int'(mem[a8(s0, -1)]), int'(pc[7:4]));
                    chk("R4", "nib -2", int'(mem[a8(s0, -2)]), int'(pc[3:0]));
                    chk("R4", "nib -3", int'(mem[a8(s0, -3)]), int'({fm, fr, 2'b00}));
                    chk("R4", "nib -4", int'(mem[a8(s0, -4)]), int'({1'b0, pc[10:8]}));
                end else begin
                    chk("R3", "long call cycles", r_cycles, 5);
                    chk("R5", "long call sp", int'(r_sp), int'(a8(s0, -6)));
                    chk("R5", "nib -1 untouched", int'(mem[a8(s0, -1)]), 4'hA);
                    chk("R5", "nib -2", int'(mem[a8(s0, -2)]), int'({2'b00, fm, fr}));
                    chk("R5", "nib -3", int'(mem[a8(s0, -3)]), int'(pc[7:4]));
                    chk("R5", "nib -4", int'(mem[a8(s0, -4)]), int'(pc[3:0]));
                    chk("R5", "nib -5", int'(mem[a8(s0, -5)]), 0);
                    chk("R5", "nib -6", int'(mem[a8(s0, -6)]), int'({1'b0, pc[10:8]}));
                end
                chk("R3", "sp after call", int'(sp), int'(r_sp));

                // set ignored bits to ones before returning
                s1 = sp;
                if (m == 0) begin
                    mem[a8(s1, 1)] = {mem[a8(s1, 1)][3:2], 2'b11};
                end else begin
                    mem[a8(s1, 1)] = 4'hF;
                    mem[a8(s1, 4)] = {2'b11, mem[a8(s1, 4)][1:0]};
                end
                run_op(k[0] ? C_RETS : C_RET, 1'b0);
                chk("R3", "return cycles", r_cycles, 4);
                chk(m == 0 ? "R6" : "R7", "return pc", int'(r_pc), int'(pc));
                chk(m == 0 ? "R6" : "R7", "return mbe", int'(r_mbe), int'(fm));
                chk(m == 0 ? "R6" : "R7", "return rbe", int'(r_rbe), int'(fr));
                chk(m == 0 ? "R6" : "R7", "return sp", int'(r_sp), int'(s0));
                chk("R8", "flags_load", int'(r_fl), 1);
                chk("R8", "skip request", int'(r_skip), int'(k[0]));
            end
        end

        // R10 pop all pairs (SP wraps back up through zero)
        for (int i = 31; i >= 0; i--) begin
            logic [7:0] s0;
            s0 = sp;
            pair_in = 8'h00;
            run_op(C_POPP, 1'b0);
            chk("R10", "pair pop value", int'(r_pair), int'(pair_hist[i]));
            chk("R10", "pair pop load", int'(r_pl), 1);
            chk("R12", "pair pop sp", int'(r_sp), int'(a8(s0, 2)));
            chk("R8", "no skip on pop", int'(r_skip), 0);
        end
        chk("R12", "sp back at zero", int'(sp), 0);

        // R11 bank push and pop
        begin
            logic [7:0] s0;
            s0 = sp;
            mbs_in = 4'h5; rbs_in = 4'hC;
            run_op(C_PUSHB, 1'b0);
            chk("R11", "bank push mbs", int'(mem[a8(s0, -1)]), 5);
            chk("R11", "bank push rbs", int'(mem[a8(s0, -2)]), 12);
            chk("R11", "bank push sp", int'(r_sp), int'(a8(s0, -2)));
            mbs_in = 4'h0; rbs_in = 4'h0;
            run_op(C_POPB, 1'b0);
            chk("R11", "bank pop mbs", int'(r_mbs), 5);
            chk("R11", "bank pop rbs", int'(r_rbs), 12);
            chk("R11", "bank pop load", int'(r_bl), 1);
            chk("R11", "bank pop sp", int'(r_sp), int'(s0));
        end

        // R9 interrupt return in both formats
        for (int m = 0; m < 2; m++) begin
            for (int j = 0; j < 4; j++) begin
                logic [7:0] s0;
                logic [10:0] epc;
                logic [7:0] epsw;
                long_mode = m[0];
                s0 = sp;
                for (int i = 0; i < 6; i++) mem[a8(s0, i)] = 4'(j * 5 + i * 3 + m * 7 + 1);
                epc  = {mem[s0][2:0], mem[a8(s0, 3)], mem[a8(s0, 2)]};
                epsw = {mem[a8(s0, 4)], mem[a8(s0, 5)]};
                run_op(C_RETI, 1'b0);
                chk("R9", "reti cycles", r_cycles, 5);
                chk("R9", "reti pc", int'(r_pc), int'(epc));
                chk("R9", "reti psw", int'(r_psw), int'(epsw));
                chk("R9", "reti psw_load", int'(r_psl), 1);
                chk("R9", "reti sp", int'(r_sp), int'(a8(s0, 6)));
                chk("R8", "no skip on reti", int'(r_skip), 0);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule